// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block picks the control-store address for the next microinstruction of a horizontally microcoded processor. Each cycle it takes the base address carried in the current control word and folds branch information into it with bitwise OR. When the dispatch control is set, the fetched opcode byte is OR-ed into the low address bits. The two conditional controls OR the latched negative flag or the latched zero flag into the top address bit. No adder and no target multiplexer are involved.

The block owns three registers: the micro-program counter and the two one-bit ALU condition flags. The flags are captured from the full ALU result at every clock edge. A conditional branch in a given microinstruction therefore tests the result produced by the microinstruction before it. All outputs are plain registered control signals. The sequencer advances on every clock and has no stall or back-pressure path.

Top module: `mpc_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, `mpc`, `flag_n` and `flag_z` are all 0 after that edge.
- R2: With `jmp_dispatch`, `jmp_neg` and `jmp_zero` all 0, `mpc` after a rising edge equals the `base_addr` present before that edge.
- R3: With `jmp_dispatch` = 1, bits 7..0 of the new `mpc` equal `base_addr[7:0] | opcode_byte`. Bit 8 is not affected by `opcode_byte`.
- R4: With `jmp_neg` = 1, bit 8 of the new `mpc` is `base_addr[8] | flag_n`, where `flag_n` is the value held before the edge.
- R5: With `jmp_zero` = 1, bit 8 of the new `mpc` is `base_addr[8] | flag_z`, where `flag_z` is the value held before the edge.
- R6: Any combination of the three jump controls may be set at once. Their OR contributions add together: bit 8 = `base_addr[8] | (jmp_neg & flag_n) | (jmp_zero & flag_z)`.
- R7: At each rising edge outside reset, `flag_n` takes `alu_result[31]`, and `flag_z` becomes 1 exactly when all 32 bits of `alu_result` are 0.
- R8: A branch tests the flags captured at the previous edge. The `alu_result` presented in the same cycle as a jump control does not influence that cycle's new `mpc`.
- R9: When `base_addr[8]` is 1, the new `mpc[8]` is 1 whatever the flags and jump controls are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 9 | Next-address field of the current control word |
| jmp_dispatch | input | 1 | OR the opcode byte into the low address bits |
| jmp_neg | input | 1 | OR the negative flag into the top address bit |
| jmp_zero | input | 1 | OR the zero flag into the top address bit |
| opcode_byte | input | 8 | Fetched instruction byte |
| alu_result | input | 32 | Raw ALU output of the current microinstruction |
| mpc | output | 9 | Registered micro-program counter (control-store address) |
| flag_n | output | 1 | Latched negative flag |
| flag_z | output | 1 | Latched zero flag |

## Verification
The bench builds the sequencer with its default widths: a 9-bit address, an 8-bit opcode byte and a 32-bit ALU result. With these widths the opcode byte covers every low address bit exactly, so a dispatch can reach any address in the lower or upper half of the control store. The sign bit at position 31 and the all-zero test over 32 bits can both be driven directly. Random control words and random ALU results, mixed with exact zeros and negative values, exercise every combination of jump controls against both flag states.

// File: rtl/mpc_seq_pkg.sv
package mpc_seq_pkg;

  // Jump control group taken from one control word
  typedef struct packed {
    logic dispatch;  // OR opcode byte into low address bits
    logic on_neg;    // OR negative flag into top bit
    logic on_zero;   // OR zero flag into top bit
  } jump_ctl_t;

endpackage

// File: rtl/mseq_flag_reg.sv
module mseq_flag_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] result,
  output logic              neg_q,
  output logic              zero_q
);

  localparam int SIGN_BIT = DATA_W - 1;

  logic neg_d;
  logic zero_d;

  always_comb begin
    neg_d  = result[SIGN_BIT];
    zero_d = (result == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      neg_q  <= neg_d;
      zero_q <= zero_d;
    end
  end

endmodule

// File: rtl/mseq_addr_merge.sv
module mseq_addr_merge
  import mpc_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int MBR_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  jump_ctl_t         ctl,
  input  logic [MBR_W-1:0]  opcode,
  input  logic              neg,
  input  logic              zero,
  output logic [ADDR_W-1:0] merged
);

  localparam int LOW_W = ADDR_W - 1;
  localparam int TOP   = ADDR_W - 1;

  logic [LOW_W-1:0] opcode_ext;

  // The opcode byte fills the low field, zero-extended when narrower
  generate
    if (MBR_W == LOW_W) begin : g_exact
      assign opcode_ext = opcode;
    end else begin : g_extend
      assign opcode_ext = {{(LOW_W - MBR_W){1'b0}}, opcode};
    end
  endgenerate

  logic top_cond;

  always_comb begin
    top_cond            = (ctl.on_neg & neg) | (ctl.on_zero & zero);
    merged[LOW_W-1:0]   = base[LOW_W-1:0] | (ctl.dispatch ? opcode_ext : '0);
    merged[TOP]         = base[TOP] | top_cond;
  end

endmodule

// File: rtl/mseq_pc_reg.sv
module mseq_pc_reg #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer
  import mpc_seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int MBR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              jmp_dispatch,
  input  logic              jmp_neg,
  input  logic              jmp_zero,
  input  logic [MBR_W-1:0]  opcode_byte,
  input  logic [DATA_W-1:0] alu_result,
  output logic [ADDR_W-1:0] mpc,
  output logic              flag_n,
  output logic              flag_z
);

  jump_ctl_t         ctl;
  logic [ADDR_W-1:0] next_pc;

  assign ctl = '{dispatch: jmp_dispatch, on_neg: jmp_neg, on_zero: jmp_zero};

  mseq_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .result (alu_result),
    .neg_q  (flag_n),
    .zero_q (flag_z)
  );

  mseq_addr_merge #(.ADDR_W(ADDR_W), .MBR_W(MBR_W)) u_merge (
    .base   (base_addr),
    .ctl    (ctl),
    .opcode (opcode_byte),
    .neg    (flag_n),
    .zero   (flag_z),
    .merged (next_pc)
  );

  mseq_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (next_pc),
    .q   (mpc)
  );

endmodule

// File: rtl/mpc_sequencer_chk.sv
module mpc_sequencer_chk #(
  parameter int ADDR_W = 9,
  parameter int MBR_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] base_addr,
  input logic              jmp_dispatch,
  input logic              jmp_neg,
  input logic              jmp_zero,
  input logic [MBR_W-1:0]  opcode_byte,
  input logic [DATA_W-1:0] alu_result,
  input logic [ADDR_W-1:0] mpc,
  input logic              flag_n,
  input logic              flag_z
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (mpc == '0) && !flag_n && !flag_z);

  // R2
  plain_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp_dispatch && !jmp_neg && !jmp_zero) |=> mpc == $past(base_addr));

  // R3
  dispatch_low_chk: assert property (@(posedge clk) disable iff (rst)
    jmp_dispatch |=> mpc[ADDR_W-2:0] == ($past(base_addr[ADDR_W-2:0]) | ADDR_W'($past(opcode_byte))));

  // R6
  top_bit_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mpc[ADDR_W-1] == ($past(base_addr[ADDR_W-1]) |
                               ($past(jmp_neg) & $past(flag_n)) |
                               ($past(jmp_zero) & $past(flag_z))));

  // R7
  flag_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_n == $past(alu_result[DATA_W-1])) && (flag_z == ($past(alu_result) == '0)));

  // R9
  top_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    base_addr[ADDR_W-1] |=> mpc[ADDR_W-1]);

endmodule

bind mpc_sequencer mpc_sequencer_chk #(
  .ADDR_W(ADDR_W), .MBR_W(MBR_W), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .base_addr    (base_addr),
  .jmp_dispatch (jmp_dispatch),
  .jmp_neg      (jmp_neg),
  .jmp_zero     (jmp_zero),
  .opcode_byte  (opcode_byte),
  .alu_result   (alu_result),
  .mpc          (mpc),
  .flag_n       (flag_n),
  .flag_z       (flag_z)
);

// File: tb/mpc_sequencer_test.sv
`timescale 1ns/1ps
module mpc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  base_addr = '0;
  logic        jmp_dispatch = 1'b0;
  logic        jmp_neg = 1'b0;
  logic        jmp_zero = 1'b0;
  logic [7:0]  opcode_byte = '0;
  logic [31:0] alu_result = '0;
  logic [8:0]  mpc;
  logic        flag_n;
  logic        flag_z;

  int checks = 0;
  int errors = 0;

  // reference state
  int ref_pc = 0;
  int ref_n  = 0;
  int ref_z  = 0;

  always #5 clk = ~clk;

  mpc_sequencer uut (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .jmp_dispatch(jmp_dispatch), .jmp_neg(jmp_neg), .jmp_zero(jmp_zero),
    .opcode_byte(opcode_byte), .alu_result(alu_result),
    .mpc(mpc), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus, reference update and comparison
  task automatic step(input string tag, input logic r, input int na,
                      input logic jd, input logic jn, input logic jz,
                      input int op, input logic [31:0] alu);
    int nxt;
    @(negedge clk);
    rst = r; base_addr = na[8:0]; jmp_dispatch = jd; jmp_neg = jn;
    jmp_zero = jz; opcode_byte = op[7:0]; alu_result = alu;
    nxt = na & 511;
    if (jd) nxt = nxt | (op & 255);
    if (jn && ref_n != 0) nxt = nxt | 256;
    if (jz && ref_z != 0) nxt = nxt | 256;
    if (r) begin
      ref_pc = 0; ref_n = 0; ref_z = 0;
    end else begin
      ref_pc = nxt;
      ref_n  = alu[31] ? 1 : 0;
      ref_z  = (alu == 32'd0) ? 1 : 0;
    end
    @(posedge clk);
    #1;
    check(tag, int'(mpc), ref_pc, "mpc");
    check(tag, {31'd0, flag_n}, ref_n, "flag_n");
    check(tag, {31'd0, flag_z}, ref_z, "flag_z");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    step("R1", 1'b1, 9'h1AB, 1, 1, 1, 8'hFF, 32'h8000_0000);
    step("R1", 1'b1, 9'h0, 0, 0, 0, 0, 32'h0);
    // R2: plain copies
    step("R2", 1'b0, 9'h123, 0, 0, 0, 8'hFF, 32'h5);
    step("R2", 1'b0, 9'h0FF, 0, 0, 0, 8'h00, 32'h7);
    step("R2", 1'b0, 9'h100, 0, 0, 0, 8'h3C, 32'h1);
    // R7: flag capture, zero then negative then positive
    step("R7", 1'b0, 9'h002, 0, 0, 0, 0, 32'h0);
    step("R7", 1'b0, 9'h003, 0, 0, 0, 0, 32'h8000_0000);
    step("R7", 1'b0, 9'h004, 0, 0, 0, 0, 32'h0000_0100);
    // R3: dispatch
    step("R3", 1'b0, 9'h000, 1, 0, 0, 8'hA5, 32'h1);
    step("R3", 1'b0, 9'h10F, 1, 0, 0, 8'hF0, 32'h1);
    step("R3", 1'b0, 9'h055, 1, 0, 0, 8'hAA, 32'hFFFF_FFFF);
    // R4: N is now 1
    step("R4", 1'b0, 9'h020, 0, 1, 0, 0, 32'h1);
    // N is now 0
    step("R4", 1'b0, 9'h021, 0, 1, 0, 0, 32'h0);
    // R5: Z is now 1
    step("R5", 1'b0, 9'h030, 0, 0, 1, 0, 32'h2);
    // Z is now 0
    step("R5", 1'b0, 9'h031, 0, 0, 1, 0, 32'h8000_0000);
    // R6: N=1, all three controls together
    step("R6", 1'b0, 9'h000, 1, 1, 1, 8'h42, 32'h0);
    step("R6", 1'b0, 9'h001, 1, 1, 1, 8'h80, 32'h3);
    // R9: top bit already set, flags clear
    step("R9", 1'b0, 9'h1C0, 0, 1, 1, 0, 32'h3);
    step("R9", 1'b0, 9'h180, 1, 0, 0, 8'h01, 32'h3);
    // R8: same-cycle ALU result must not steer the branch
    step("R8", 1'b0, 9'h044, 0, 0, 1, 0, 32'h0);
    step("R8", 1'b0, 9'h045, 0, 1, 0, 0, 32'h8000_0000);
    // random mix of control words and flags
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 32'h0 : (sel == 1) ? ($urandom | 32'h8000_0000) : $urandom;
      step("R6", 1'b0, int'($urandom_range(0, 511)), 1'($urandom), 1'($urandom),
           1'($urandom), int'($urandom_range(0, 255)), a);
    end
    // R1: reset in the middle of a run
    step("R1", 1'b1, 9'h1FF, 1, 1, 1, 8'hFF, 32'h0);
    step("R2", 1'b0, 9'h0AA, 0, 0, 0, 0, 32'h9);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule